// File: doc/BRIEF.md
# Montgomery Modular Exponentiator

This block raises a message to an exponent modulo an odd number, x^e mod n. Every multiplication goes through a digit-serial Montgomery product engine held inside the same module. The engine retires one D-bit digit of its first operand per clock and uses the folding constant n' = -n^-1 mod 2^D. A control sequence walks the exponent from its most significant set bit down to bit 0. For each bit it squares the accumulator, and when the bit is set it then multiplies the accumulator by the message.

Entry into the Montgomery domain uses products against R^2 mod n, where R = 2^W. The product of x with R^2 gives x·R mod n. The product of 1 with R^2 gives R mod n, the domain image of 1, which seeds the accumulator. The last product is taken against 1 and brings the accumulator back out as x^e mod n. The caller supplies n' and R^2 mod n. When the KEEP_R2 variant is built, the R^2 value captured on an earlier request can be reused, so the caller does not have to present it again for a fixed modulus.

A request is a single-cycle `start` pulse taken while the block is idle. `busy` stays high until the single-cycle `done` pulse, and `result` then holds its value until the next request finishes.

Top module: `mont_exp`

## Requirements
- R1: While reset is held, `busy`, `done` and `result` are all 0.
- R2: For odd n, x < n, nprime = -n^-1 mod 2^D and r2 = 2^(2W) mod n, `result` equals x^e mod n in the cycle in which `done` is high.
- R3: An exponent of 0 yields 1 mod n.
- R4: Leading zero exponent bits cost nothing. `done` rises exactly K·(W/D+2) rising edges after the edge that accepts `start`. K = 3 for e = 0, and otherwise K = 3 + (index of the highest set bit of e) + (number of set bits of e).
- R5: `done` is high for one cycle only, and `busy` is high from the accepting edge through the `done` cycle and low in the cycle after it.
- R6: A `start` pulse given while `busy` is high is ignored: the running result and its timing are unchanged, and no extra `done` follows.
- R7: With KEEP_R2 = 1, a request with `reuse_r2` = 1 ignores the `r2` input and uses the R^2 value captured by the most recent request that had `reuse_r2` = 0.
- R8: `result` does not change while the block is idle, whatever the inputs do.
- R9: The value presented with `done` is always below n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, taken only while idle |
| reuse_r2 | input | 1 | Keep the stored R^2 instead of loading `r2` |
| x | input | W | Message, below n |
| e | input | EW | Exponent |
| n | input | W | Odd modulus |
| nprime | input | D | -n^-1 mod 2^D |
| r2 | input | W | 2^(2W) mod n |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | W | x^e mod n, held until the next completion |

## Verification
The bench builds the block with W = 32, D = 8, EW = 32 and KEEP_R2 = 1. With these values every product takes six cycles, and a 32-bit modulus lets a 64-bit reference compute the expected powers exactly. Short and all-ones exponents, exponent 0, 1, 5, 17 and 65537 all finish within a few hundred cycles. This gives direct coverage of the skip of leading zeros, the latency formula, and reuse of a stored R^2 against deliberately wrong `r2` values.

// File: rtl/mont_exp.sv
module mont_exp #(
  parameter int W       = 32,
  parameter int D       = 8,
  parameter int EW      = 32,
  parameter bit KEEP_R2 = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          reuse_r2,
  input  logic [W-1:0]  x,
  input  logic [EW-1:0] e,
  input  logic [W-1:0]  n,
  input  logic [D-1:0]  nprime,
  input  logic [W-1:0]  r2,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  result
);
  localparam int STEPS = W / D;
  localparam int AW    = W + D + 2;
  localparam int CW    = $clog2(STEPS + 1);
  localparam int IW    = $clog2(EW);
  localparam logic [CW-1:0] LAST = CW'(STEPS);

  typedef enum logic [2:0] {
    ST_IDLE, ST_CONVERT, ST_INIT, ST_SQUARE, ST_MULTIPLY, ST_FINAL, ST_DONE
  } st_t;

  st_t           state;
  logic          launch, pbusy;
  logic [CW-1:0] pcnt;
  logic [W-1:0]  pa, pb;
  logic [AW-1:0] pacc;
  logic [W-1:0]  x_q, n_q, r2_q, xm, acc_r;
  logic [EW-1:0] e_q;
  logic [D-1:0]  np_q;
  logic [IW-1:0] idx;

  function automatic logic [IW-1:0] top_bit(input logic [EW-1:0] v);
    top_bit = '0;
    for (int i = 0; i < EW; i++)
      if (v[i]) top_bit = i[IW-1:0];
  endfunction

  logic          accept;
  logic [AW-1:0] t1, pnext, nx;
  logic [D-1:0]  q;
  logic [W-1:0]  pres, op_a, op_b;
  logic          prod_done;

  assign accept = (state == ST_IDLE) && start;
  assign busy   = (state != ST_IDLE);
  assign done   = (state == ST_DONE);

  assign nx        = {{(AW-W){1'b0}}, n_q};
  assign t1        = pacc + {{(AW-D){1'b0}}, pa[D-1:0]} * {{(AW-W){1'b0}}, pb};
  assign q         = t1[D-1:0] * np_q;
  assign pnext     = (t1 + {{(AW-D){1'b0}}, q} * nx) >> D;
  assign prod_done = pbusy && (pcnt == LAST);
  assign pres      = (pacc >= nx) ? pacc[W-1:0] - n_q : pacc[W-1:0];

  always_comb begin
    op_a = acc_r;
    op_b = acc_r;
    case (state)
      ST_CONVERT:  begin op_a = x_q;           op_b = r2_q; end
      ST_INIT:     begin op_a = W'(1);         op_b = r2_q; end
      ST_MULTIPLY: begin op_a = acc_r;         op_b = xm;   end
      ST_FINAL:    begin op_a = acc_r;         op_b = W'(1); end
      default:     begin op_a = acc_r;         op_b = acc_r; end
    endcase
  end

  generate
    if (KEEP_R2) begin : g_keep
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                   r2_q <= '0;
        else if (accept && !reuse_r2) r2_q <= r2;
    end else begin : g_load
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)      r2_q <= '0;
        else if (accept) r2_q <= r2;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      launch <= 1'b0;
      pbusy  <= 1'b0;
      pcnt   <= '0;
      pa     <= '0;
      pb     <= '0;
      pacc   <= '0;
      x_q    <= '0;
      e_q    <= '0;
      n_q    <= '0;
      np_q   <= '0;
      xm     <= '0;
      acc_r  <= '0;
      idx    <= '0;
      result <= '0;
    end else begin
      if (launch) begin
        pa     <= op_a;
        pb     <= op_b;
        pacc   <= '0;
        pcnt   <= '0;
        pbusy  <= 1'b1;
        launch <= 1'b0;
      end else if (pbusy && !prod_done) begin
        pacc <= pnext;
        pa   <= pa >> D;
        pcnt <= pcnt + 1'b1;
      end else if (prod_done) begin
        pbusy <= 1'b0;
      end

      case (state)
        ST_IDLE: if (start) begin
          x_q    <= x;
          e_q    <= e;
          n_q    <= n;
          np_q   <= nprime;
          idx    <= top_bit(e);
          launch <= 1'b1;
          state  <= ST_CONVERT;
        end
        ST_CONVERT: if (prod_done) begin
          xm     <= pres;
          launch <= 1'b1;
          state  <= ST_INIT;
        end
        ST_INIT: if (prod_done) begin
          acc_r  <= pres;
          launch <= 1'b1;
          state  <= (e_q == '0) ? ST_FINAL : ST_MULTIPLY;
        end
        ST_MULTIPLY: if (prod_done) begin
          acc_r  <= pres;
          launch <= 1'b1;
          if (idx == '0) state <= ST_FINAL;
          else begin
            idx   <= idx - 1'b1;
            state <= ST_SQUARE;
          end
        end
        ST_SQUARE: if (prod_done) begin
          acc_r  <= pres;
          launch <= 1'b1;
          if (e_q[idx])        state <= ST_MULTIPLY;
          else if (idx == '0)  state <= ST_FINAL;
          else                 idx   <= idx - 1'b1;
        end
        ST_FINAL: if (prod_done) begin
          result <= pres;
          state  <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

module mont_exp_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] result,
  input logic [W-1:0] n_q
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                   // R5
  AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);                                   // R5
  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);                                    // R5
  AST_START_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);                        // R5
  AST_RESULT_REDUCED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result < n_q));                          // R9
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(result));                        // R8
endmodule

bind mont_exp mont_exp_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .result(result), .n_q(n_q)
);

// File: tb/mont_exp_bench.sv
module mont_exp_bench;
  localparam int W = 32, D = 8, EW = 32;
  localparam int PCYC = W / D + 2;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          start = 1'b0, reuse_r2 = 1'b0;
  logic [W-1:0]  x = '0, n = '0, r2 = '0;
  logic [EW-1:0] e = '0;
  logic [D-1:0]  nprime = '0;
  logic          busy, done;
  logic [W-1:0]  result;

  mont_exp #(.W(W), .D(D), .EW(EW), .KEEP_R2(1'b1)) u_mont_exp (
    .clk(clk), .rst_n(rst_n), .start(start), .reuse_r2(reuse_r2),
    .x(x), .e(e), .n(n), .nprime(nprime), .r2(r2),
    .busy(busy), .done(done), .result(result)
  );

  always #4 clk = ~clk;

  int     checks = 0, errors = 0;
  longint cyc = 0;
  logic [W-1:0] last_res = '0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [W-1:0] q_res[$];
  logic [W-1:0] q_mod[$];
  longint       q_cyc[$];
  string        q_tag[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exv);
    end
  endtask

  function automatic logic [W-1:0] ref_pow(input logic [W-1:0] b0, input logic [EW-1:0] ex, input logic [W-1:0] m);
    logic [63:0] r, b, mm;
    mm = {32'd0, m};
    r  = 64'd1 % mm;
    b  = {32'd0, b0} % mm;
    for (int i = 0; i < EW; i++) begin
      if (ex[i]) r = (r * b) % mm;
      b = (b * b) % mm;
    end
    return r[W-1:0];
  endfunction

  function automatic logic [W-1:0] calc_r2(input logic [W-1:0] m);
    logic [63:0] r;
    r = 64'd1 % {32'd0, m};
    repeat (2 * W) r = (r << 1) % {32'd0, m};
    return r[W-1:0];
  endfunction

  function automatic logic [D-1:0] calc_np(input logic [W-1:0] m);
    logic [D-1:0] inv;
    inv = m[D-1:0];
    repeat (4) inv = inv * (8'd2 - m[D-1:0] * inv);
    return 8'd0 - inv;
  endfunction

  function automatic longint n_prod(input logic [EW-1:0] ex);
    int hi, pc;
    hi = 0; pc = 0;
    for (int i = 0; i < EW; i++) if (ex[i]) begin hi = i; pc++; end
    return (ex == '0) ? 3 : 3 + hi + pc;
  endfunction

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q_res.size() == 0) begin
        chk(1'b0, "R6 unexpected done", 64'(result), 64'd0);
      end else begin
        logic [W-1:0] er, em; longint ec; string tg;
        er = q_res.pop_front(); em = q_mod.pop_front();
        ec = q_cyc.pop_front(); tg = q_tag.pop_front();
        chk(result == er, tg, 64'(result), 64'(er));
        chk(cyc == ec, "R4 latency", 64'(cyc), 64'(ec));
        chk(result < em, "R9 reduced", 64'(result), 64'(em));
        last_res = er;
      end
    end
  end

  task automatic run_op(input logic [W-1:0] xi, input logic [EW-1:0] ei, input logic [W-1:0] ni,
                        input bit reuse, input bit bad_r2, input bit poke, input string tag);
    @(negedge clk);
    x = xi; e = ei; n = ni; nprime = calc_np(ni);
    r2 = bad_r2 ? 32'hDEAD_BEEF : calc_r2(ni);
    reuse_r2 = reuse; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    q_res.push_back(ref_pow(xi, ei, ni));
    q_mod.push_back(ni);
    q_cyc.push_back(cyc + n_prod(ei) * PCYC);
    q_tag.push_back(tag);
    if (poke) begin
      repeat (3) @(negedge clk);
      x = 32'h1234_5678 % ni; e = 32'h0000_0003; r2 = 32'h5555_5555; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    do @(negedge clk); while (busy);
  endtask

  localparam logic [W-1:0] NBIG = 32'hF123_4567;
  localparam logic [W-1:0] NSML = 32'd197;

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy", 64'(busy), 64'd0);
    chk(done == 1'b0, "R1 done", 64'(done), 64'd0);
    chk(result == '0, "R1 result", 64'(result), 64'd0);
    rst_n = 1'b1;

    run_op(32'h0ABC_DEF1, 32'd5,           NBIG, 1'b0, 1'b0, 1'b0, "R2 e=5");
    run_op(32'h7777_1234, 32'd17,          NBIG, 1'b0, 1'b0, 1'b0, "R2 e=17");
    run_op(32'd123,       32'd17,          NSML, 1'b0, 1'b0, 1'b0, "R2 small n e=17");
    run_op(32'h0123_4567, 32'd65537,       NBIG, 1'b0, 1'b0, 1'b0, "R2 e=65537");
    run_op(32'hF123_4566, 32'hFFFF_FFFF,   NBIG, 1'b0, 1'b0, 1'b0, "R2 e=all ones");
    run_op(32'd0,         32'd9,           NBIG, 1'b0, 1'b0, 1'b0, "R2 x=0");
    run_op(32'h3333_3333, 32'd1,           NBIG, 1'b0, 1'b0, 1'b0, "R2 e=1");
    run_op(32'h3333_3333, 32'd0,           NBIG, 1'b0, 1'b0, 1'b0, "R3 e=0");
    run_op(32'd55,        32'd0,           NSML, 1'b0, 1'b0, 1'b0, "R3 e=0 small n");
    run_op(32'h0000_0002, 32'h8000_0000,   NBIG, 1'b0, 1'b0, 1'b0, "R4 single high bit");

    run_op(32'h0BAD_F00D, 32'd12345,       NBIG, 1'b0, 1'b0, 1'b0, "R7 load r2");
    run_op(32'h0000_BEEF, 32'd17,          NBIG, 1'b1, 1'b1, 1'b0, "R7 reuse, r2 garbage");
    run_op(32'h0101_0101, 32'd300,         NBIG, 1'b1, 1'b1, 1'b0, "R7 reuse again");

    run_op(32'h0246_8ACE, 32'd1000,        NBIG, 1'b0, 1'b0, 1'b1, "R6 start while busy");
    repeat (2 * PCYC * 10) @(negedge clk);
    chk(busy == 1'b0, "R6 stays idle", 64'(busy), 64'd0);
    chk(q_res.size() == 0, "R6 no pending", 64'(q_res.size()), 64'd0);

    x = 32'h1111_1111; e = 32'd7; n = NSML; r2 = 32'h2222_2222;
    repeat (20) @(negedge clk);
    chk(result == last_res, "R8 held while idle", 64'(result), 64'(last_res));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule